// File: doc/BRIEF.md
# Nested Interrupt Level Controller

This block keeps track of the interrupt service level of a processor core that runs in nested mode. Seven ordinary priority levels exist, numbered 0 to 6, and level 0 has the highest priority. The value 7 stands for the idle/base level, where no routine is in service. When a request arrives whose priority is higher than the level now in service, the block moves the core to the new level. If the interrupted level was a real level, the block records it in a hold-level bitmap. A return-from-interrupt strobe undoes one step of nesting: the most recently interrupted level is taken out of the bitmap and becomes the service level again.

Next to the ordinary levels, the block builds a top-level request that sits above the whole level scheme. Its pending flag is set in one of two ways, chosen by software. One is a watchdog end-of-count pulse. The other is a selected edge of an asynchronous NMI pin, which first passes through a synchronizer. Software can make this request non-maskable through a sticky bit that only reset clears.

Two byte-wide control registers are written through a simple port. The vector/control register is also driven back out as the vector byte. A separate output forwards channel A0, which takes either the watchdog pulse or an external pin.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the state is as follows:
  - `cur_level_o` is 7 (idle).
  - `hold_o` is 0.
  - `top_req_o` is 0.
  - The non-maskable bit is clear.
  - `vec_o[3:0]` is 4'b0110. The fields are bit0 trigger edge, bit1 top-level source, bit2 A0 source and bit3 wait enable.
- R2: A request is taken when `gie_i` is 1 and the lowest-numbered asserted line of `req_i` is below `cur_level_o`. One cycle later `cur_level_o` equals that line's number. Requests at an equal or lower priority are ignored, and so are all requests while `gie_i` is 0.
- R3: When a request is taken while the current level L is 0..6, bit L of `hold_o` is set. A request taken from idle sets no bit. Acknowledging the top-level interrupt changes neither `hold_o` nor `cur_level_o`.
- R4: On `iret_i`, the lowest-numbered set bit of `hold_o` is cleared and becomes `cur_level_o`. If no bit is set, `cur_level_o` becomes 7. When `iret_i` and a takeable request arrive in the same cycle, the return is done first and the request is judged in the next cycle.
- R5: A write with `wr_sel_i`=1 and `wr_data_i[7]`=1 sets the non-maskable bit. Writing 0 there has no effect, only reset clears the bit, and bits 6:0 of that write are ignored (they leave `hold_o` unchanged).
- R6: While the top level is maskable, `top_req_o` = pending AND `gie_i` AND `top_en_i`. While it is non-maskable, `top_req_o` = pending.
- R7: `vec_o[1]` selects the source of the pending flag. With 0, a high `wdg_eoc_i` sets pending; with 1, an NMI edge sets it. The unselected source has no effect.
- R8: `vec_o[0]` selects the NMI edge: 0 means falling and 1 means rising. The opposite edge is ignored. `nmi_i` goes through two synchronizer flops, so pending is set on the third clock edge after the pin changes.
- R9: `top_ack_i` clears pending. If a source event arrives in the same cycle, pending stays set.
- R10: `a0_irq_o` follows `ext_int_i` when `vec_o[2]` is 1, and follows `wdg_eoc_i` when it is 0.
- R11: A write with `wr_sel_i`=0 loads all eight bits, and the value appears on `vec_o` on the next cycle. Bits 7:4 form the vector nibble, which reset does not initialize.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 7 | Per-level request lines; bit n belongs to level n |
| iret_i | input | 1 | Return-from-interrupt strobe |
| gie_i | input | 1 | Global interrupt enable |
| top_en_i | input | 1 | Top-level interrupt enable |
| top_ack_i | input | 1 | CPU acknowledge of the top-level interrupt |
| wdg_eoc_i | input | 1 | Watchdog end-of-count pulse |
| nmi_i | input | 1 | Asynchronous NMI pin |
| ext_int_i | input | 1 | External interrupt pin for channel A0 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = vector/control register, 1 = nested control register |
| wr_data_i | input | 8 | Write data |
| cur_level_o | output | 3 | Level now in service; 7 = idle |
| hold_o | output | 7 | Bitmap of preempted levels |
| top_req_o | output | 1 | Top-level interrupt request |
| vec_o | output | 8 | Vector/control register contents |
| a0_irq_o | output | 1 | Channel A0 request |

## Verification
Two pairs of events can land in the same cycle. The first pair is a return and a new higher-priority request. The bench holds a return strobe and a request line high together while a preempted level is stored. It expects the return to restore the stored level first and the request to be taken one cycle later, which puts the restored level back into the bitmap. The second pair is a top-level acknowledge and a fresh watchdog pulse. The bench raises both in one cycle and expects the pending request to remain.

// File: rtl/nilc_pkg.sv
package nilc_pkg;

   // Vector/control register layout, MSB first.
   typedef struct packed {
      logic [3:0] vhi;        // vector nibble, not reset
      logic       wait_en;    // stored only
      logic       a0_ext;     // 1: channel A0 from external pin
      logic       top_nmi;    // 1: top-level source is the NMI pin
      logic       trig_rise;  // 1: rising NMI edge, 0: falling
   } vctl_t;

   localparam logic [3:0] VCTL_LOW_RST = 4'b0110;

endpackage

// File: rtl/nilc_pick.sv
// Lowest-index set bit finder; returns W when no bit is set.
module nilc_pick #(
   parameter int W  = 7,
   parameter int IW = 3
) (
   input  logic [W-1:0]  vec_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);

   always_comb begin
      idx_o = IW'(W);
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end

   assign any_o = |vec_i;

endmodule

// File: rtl/nilc_ctl_regs.sv
module nilc_ctl_regs
   import nilc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en_i,
   input  logic       wr_sel_i,
   input  logic [7:0] wr_data_i,
   output vctl_t      vctl_o,
   output logic       nm_o
);

   logic [3:0] vhi_q;
   logic [3:0] low_q;
   logic       nm_q;

   // Vector nibble carries no reset.
   always_ff @(posedge clk) begin
      if (wr_en_i && !wr_sel_i) vhi_q <= wr_data_i[7:4];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_q <= VCTL_LOW_RST;
      end else if (wr_en_i && !wr_sel_i) begin
         low_q <= wr_data_i[3:0];
      end
   end

   // Set-only; reset is the sole way back to 0.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nm_q <= 1'b0;
      end else if (wr_en_i && wr_sel_i && wr_data_i[7]) begin
         nm_q <= 1'b1;
      end
   end

   assign vctl_o = vctl_t'({vhi_q, low_q});
   assign nm_o   = nm_q;

endmodule

// File: rtl/nilc_top_src.sv
module nilc_top_src #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_i,
   input  logic wdg_i,
   input  logic trig_rise_i,
   input  logic src_nmi_i,
   input  logic ack_i,
   output logic pend_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   pend_q;
   logic                   pin_s;
   logic                   edge_hit;
   logic                   evt;

   generate
      if (SYNC_STAGES == 2) begin : g_sync2
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[0], nmi_i};
         end
      end else begin : g_syncn
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], nmi_i};
         end
      end
   endgenerate

   assign pin_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_s;
   end

   assign edge_hit = trig_rise_i ? (pin_s & ~prev_q) : (~pin_s & prev_q);
   assign evt      = src_nmi_i ? edge_hit : wdg_i;

   // A new event outranks the acknowledge.
   always_ff @(posedge clk) begin
      if (!rst_n)     pend_q <= 1'b0;
      else if (evt)   pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/nilc_level_stack.sv
module nilc_level_stack #(
   parameter int NUM_LEVELS = 7,
   parameter int LW         = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] req_i,
   input  logic                  gie_i,
   input  logic                  iret_i,
   output logic [LW-1:0]         cur_o,
   output logic [NUM_LEVELS-1:0] hold_o
);

   localparam logic [LW-1:0] IDLE = LW'(NUM_LEVELS);

   logic [LW-1:0]         cur_q;
   logic [NUM_LEVELS-1:0] hold_q;
   logic                  req_any;
   logic [LW-1:0]         req_idx;
   logic                  hold_any;
   logic [LW-1:0]         hold_idx;
   logic [NUM_LEVELS-1:0] cur_oh;
   logic [NUM_LEVELS-1:0] back_oh;
   logic                  take;

   nilc_pick #(.W(NUM_LEVELS), .IW(LW)) u_req_pick (
      .vec_i (req_i),
      .any_o (req_any),
      .idx_o (req_idx)
   );

   nilc_pick #(.W(NUM_LEVELS), .IW(LW)) u_hold_pick (
      .vec_i (hold_q),
      .any_o (hold_any),
      .idx_o (hold_idx)
   );

   always_comb begin
      for (int i = 0; i < NUM_LEVELS; i++) begin
         cur_oh[i]  = (cur_q == LW'(i));
         back_oh[i] = hold_any && (hold_idx == LW'(i));
      end
   end

   assign take = gie_i && req_any && (req_idx < cur_q) && !iret_i;

   // Return outranks a take in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= IDLE;
         hold_q <= '0;
      end else if (iret_i) begin
         hold_q <= hold_q & ~back_oh;
         cur_q  <= hold_idx;
      end else if (take) begin
         hold_q <= hold_q | cur_oh;
         cur_q  <= req_idx;
      end
   end

   assign cur_o  = cur_q;
   assign hold_o = hold_q;

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nilc_pkg::*;
#(
   parameter int NUM_LEVELS  = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_LEVELS-1:0]              req_i,
   input  logic                               iret_i,
   input  logic                               gie_i,
   input  logic                               top_en_i,
   input  logic                               top_ack_i,
   input  logic                               wdg_eoc_i,
   input  logic                               nmi_i,
   input  logic                               ext_int_i,
   input  logic                               wr_en_i,
   input  logic                               wr_sel_i,
   input  logic [7:0]                         wr_data_i,
   output logic [$clog2(NUM_LEVELS+1)-1:0]    cur_level_o,
   output logic [NUM_LEVELS-1:0]              hold_o,
   output logic                               top_req_o,
   output logic [7:0]                         vec_o,
   output logic                               a0_irq_o
);

   localparam int LW = $clog2(NUM_LEVELS + 1);

   generate
      if (NUM_LEVELS < 1 || NUM_LEVELS > 15) begin : g_bad_levels
         $error("nest_irq_ctrl: NUM_LEVELS must lie in 1..15");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("nest_irq_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   vctl_t vctl;
   logic  nm_w;
   logic  pend_w;

   nilc_ctl_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .vctl_o    (vctl),
      .nm_o      (nm_w)
   );

   nilc_top_src #(.SYNC_STAGES(SYNC_STAGES)) u_top (
      .clk         (clk),
      .rst_n       (rst_n),
      .nmi_i       (nmi_i),
      .wdg_i       (wdg_eoc_i),
      .trig_rise_i (vctl.trig_rise),
      .src_nmi_i   (vctl.top_nmi),
      .ack_i       (top_ack_i),
      .pend_o      (pend_w)
   );

   nilc_level_stack #(.NUM_LEVELS(NUM_LEVELS), .LW(LW)) u_stack (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .gie_i  (gie_i),
      .iret_i (iret_i),
      .cur_o  (cur_level_o),
      .hold_o (hold_o)
   );

   assign top_req_o = pend_w & (nm_w | (gie_i & top_en_i));
   assign a0_irq_o  = vctl.a0_ext ? ext_int_i : wdg_eoc_i;
   assign vec_o     = vctl;

endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
   parameter int NUM_LEVELS = 7,
   parameter int LW         = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  iret_i,
   input logic                  gie_i,
   input logic                  top_en_i,
   input logic [LW-1:0]         cur,
   input logic [NUM_LEVELS-1:0] hold,
   input logic                  nm,
   input logic                  pend,
   input logic                  top_req
);

   logic [NUM_LEVELS-1:0] cur_oh;
   logic [NUM_LEVELS-1:0] upto;

   always_comb begin
      for (int i = 0; i < NUM_LEVELS; i++) begin
         cur_oh[i] = (cur == LW'(i));
         upto[i]   = (LW'(i) <= cur);
      end
   end

   // R3
   hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iret_i |=> ((hold & ~$past(hold) & ~$past(cur_oh)) == '0));

   // R2
   level_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold & upto) == '0);

   // R4
   iret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iret_i && hold != '0) |=> ($countones(hold) == $countones($past(hold)) - 1));

   // R4
   iret_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iret_i && hold == '0) |=> (cur == LW'(NUM_LEVELS)));

   // R5
   nm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nm |=> nm);

   // R6
   nm_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nm && pend) |-> top_req);

   // R6
   mask_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (top_req && !nm) |-> (gie_i && top_en_i && pend));

endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.NUM_LEVELS(NUM_LEVELS), .LW(LW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .iret_i   (iret_i),
   .gie_i    (gie_i),
   .top_en_i (top_en_i),
   .cur      (cur_level_o),
   .hold     (hold_o),
   .nm       (nm_w),
   .pend     (pend_w),
   .top_req  (top_req_o)
);

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] req_i = '0;
   logic       iret_i = 1'b0;
   logic       gie_i = 1'b1;
   logic       top_en_i = 1'b1;
   logic       top_ack_i = 1'b0;
   logic       wdg_eoc_i = 1'b0;
   logic       nmi_i = 1'b0;
   logic       ext_int_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic       wr_sel_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic [2:0] cur_level_o;
   logic [6:0] hold_o;
   logic       top_req_o;
   logic [7:0] vec_o;
   logic       a0_irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int         mcur = 7;
   logic [6:0] mhold = '0;

   always #4 clk = ~clk;

   nest_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .iret_i(iret_i), .gie_i(gie_i),
      .top_en_i(top_en_i), .top_ack_i(top_ack_i), .wdg_eoc_i(wdg_eoc_i),
      .nmi_i(nmi_i), .ext_int_i(ext_int_i), .wr_en_i(wr_en_i),
      .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .cur_level_o(cur_level_o),
      .hold_o(hold_o), .top_req_o(top_req_o), .vec_o(vec_o), .a0_irq_o(a0_irq_o)
   );

   task automatic step(int n = 1);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_lvl(string tag);
      check({tag, " level"}, int'(cur_level_o), mcur);
      check({tag, " hold"}, int'(hold_o), int'(mhold));
   endtask

   task automatic take(int l);
      req_i = 7'(1 << l);
      step();
      req_i = '0;
      if (gie_i && l < mcur) begin
         if (mcur != 7) mhold[mcur] = 1'b1;
         mcur = l;
      end
   endtask

   task automatic ret();
      iret_i = 1'b1;
      step();
      iret_i = 1'b0;
      if (mhold == '0) mcur = 7;
      else begin
         int lo = 7;
         for (int i = 6; i >= 0; i--) if (mhold[i]) lo = i;
         mhold[lo] = 1'b0;
         mcur = lo;
      end
   endtask

   task automatic wr(bit sel, logic [7:0] d);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
      step();
      wr_en_i = 1'b0;
   endtask

   task automatic ack();
      top_ack_i = 1'b1;
      step();
      top_ack_i = 1'b0;
   endtask

   task automatic wdg_pulse();
      wdg_eoc_i = 1'b1;
      step();
      wdg_eoc_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 level", int'(cur_level_o), 7);
      check("R1 hold", int'(hold_o), 0);
      check("R1 top_req", int'(top_req_o), 0);
      check("R1 vec low", int'(vec_o[3:0]), 6);

      // R2 R3 R4 pair sweep from idle
      for (int a = 0; a < 7; a++) begin
         for (int b = 0; b < 7; b++) begin
            take(a);
            check_lvl("R2 first take");
            take(b);
            check_lvl("R3 second take");
            ret();
            check_lvl("R4 return one");
            if (mcur != 7) begin
               ret();
               check_lvl("R4 return two");
            end
         end
      end

      // R3 R4 full chain 6 down to 0
      for (int l = 6; l >= 0; l--) take(l);
      check_lvl("R3 full chain");
      for (int k = 0; k < 8; k++) begin
         ret();
         check_lvl("R4 unwind");
      end

      // R2 gie low blocks taking
      gie_i = 1'b0;
      take(3);
      check_lvl("R2 gie low");
      gie_i = 1'b1;

      // R4 return and request in the same cycle
      take(5);
      take(3);
      req_i = 7'b001_0000;
      iret_i = 1'b1;
      step();
      iret_i = 1'b0;
      check("R4 iret first level", int'(cur_level_o), 5);
      check("R4 iret first hold", int'(hold_o), 0);
      step();
      req_i = '0;
      check("R4 deferred take level", int'(cur_level_o), 4);
      check("R4 deferred take hold", int'(hold_o), 32);
      mcur = 4; mhold = 7'b010_0000;
      ret();
      ret();
      check_lvl("R4 back to idle");

      // R8 falling edge default, NMI source default
      nmi_i = 1'b1;
      step(4);
      check("R8 rising ignored in falling mode", int'(top_req_o), 0);
      nmi_i = 1'b0;
      step(2);
      check("R8 not before third edge", int'(top_req_o), 0);
      step();
      check("R8 falling sets pending", int'(top_req_o), 1);
      // R6 maskable combinations
      for (int g = 0; g < 2; g++) begin
         for (int e = 0; e < 2; e++) begin
            gie_i = g[0]; top_en_i = e[0];
            #1;
            check("R6 maskable gating", int'(top_req_o), g & e);
         end
      end
      gie_i = 1'b1; top_en_i = 1'b1;
      ack();
      check("R9 ack clears", int'(top_req_o), 0);

      // R11 R8 rising mode
      wr(1'b0, 8'h07);
      check("R11 vec write", int'(vec_o), 8'h07);
      nmi_i = 1'b1;
      step(4);
      check("R8 rising sets", int'(top_req_o), 1);
      ack();
      nmi_i = 1'b0;
      step(4);
      check("R8 falling ignored in rising mode", int'(top_req_o), 0);

      // R7 watchdog source
      wr(1'b0, 8'hA5);
      check("R11 vec nibble", int'(vec_o), 8'hA5);
      nmi_i = 1'b1;
      step(4);
      check("R7 NMI ignored with watchdog source", int'(top_req_o), 0);
      wdg_pulse();
      check("R7 watchdog sets", int'(top_req_o), 1);
      top_ack_i = 1'b1; wdg_eoc_i = 1'b1;
      step();
      top_ack_i = 1'b0; wdg_eoc_i = 1'b0;
      check("R9 event beats ack", int'(top_req_o), 1);
      ack();
      check("R9 later ack clears", int'(top_req_o), 0);

      // R3 top-level ack leaves levels untouched
      take(6);
      take(2);
      wdg_pulse();
      ack();
      check_lvl("R3 top ack no hold change");

      // R5 low bits of nested write ignored
      wr(1'b1, 8'h7F);
      check_lvl("R5 nested low bits ignored");
      check("R5 no nm from bit6..0", int'(top_req_o), 0);
      ret();
      ret();

      // R5 R6 non-maskable
      gie_i = 1'b0; top_en_i = 1'b0;
      wdg_pulse();
      check("R6 masked while maskable", int'(top_req_o), 0);
      wr(1'b1, 8'h80);
      check("R5 nm set makes request", int'(top_req_o), 1);
      wr(1'b1, 8'h00);
      check("R5 write zero ignored", int'(top_req_o), 1);
      ack();
      check("R6 nm follows pending", int'(top_req_o), 0);
      gie_i = 1'b1; top_en_i = 1'b1;

      // R10 channel A0 routing
      for (int s = 0; s < 2; s++) begin
         wr(1'b0, s[0] ? 8'hA5 : 8'hA1);
         for (int v = 0; v < 4; v++) begin
            ext_int_i = v[0]; wdg_eoc_i = v[1];
            #1;
            check("R10 A0 routing", int'(a0_irq_o), s[0] ? v[0] : v[1]);
         end
         ext_int_i = 1'b0; wdg_eoc_i = 1'b0;
         step();
         ack();
      end

      finish_run();
   end

endmodule